// File: doc/BRIEF.md
# Flash Program/Erase Control Front End

This block sits between a simple synchronous register bus and an embedded flash array. Software reaches five registers through it: a key register, an option-key register, a status register, a control register and an address register. It can also write half-words straight into the flash address window. Each key register must receive the two unlock words in a fixed order before the matching part of the control register accepts writes. After that, software can set a programming mode, a page-erase mode or a mass-erase mode, and launch an operation. The array behind the block is a behavioural stub. Every operation on it takes a parameterised number of cycles, and all of its cells come out of reset erased (0xFFFF).

While an operation runs, a busy flag is raised and every new request is refused. When the operation ends, an end-of-operation flag is set. A request that targets a protected page sets a write-protection error flag. A program request that targets a half-word which is not erased sets a programming error flag. In both cases the array is not touched. Each flag is cleared by writing 1 to its bit. A two-bit result output gives the status in priority order, so that a polling loop can decide with one compare.

Top module: `flash_pe_ctrl`

## Requirements
- R1: After reset the control register reads 0x80 (lock bit 7 set, all mode bits 0). The status register reads 0, `busy` is 0, `op_state` is 0, and every half-word of the array reads 0xFFFF.
- R2: Writing 0x45670123 and then 0xCDEF89AB to the key register (index 0) unlocks the control register (index 3). Bit 7 then reads 0, and the mode bits PG (bit 0), PER (bit 1) and MER (bit 2) take the written values.
- R3: A key-register write that breaks the sequence locks the control register until reset. This covers a wrong first word and a second word other than 0xCDEF89AB. A later correct sequence has no effect, and control writes keep reading back 0x80.
- R4: Writing a 1 to control bit 7 relocks the control register and clears every mode bit. Writing 0 to bit 7 while locked does not unlock. The keys unlock it again.
- R5: The option bits OPTPG (bit 4) and OPTER (bit 5) keep the value 0 until the same two words have been written, in order, to the option-key register (index 1). A relock clears them and requires that sequence again.
- R6: With PG set, a write to the flash window at an erased half-word starts one program operation. `busy` (status bit 0) is 1 for exactly OP_LAT cycles. The half-word then holds the data and EOP (status bit 5) is set. A 32-bit word is stored as two such writes: the low half at address a, the high half at a+2.
- R7: A program write to a half-word that is not 0xFFFF sets PGERR (status bit 2) in the next cycle. No operation starts and the content does not change.
- R8: Writing control bit 6 (STRT) with PER set erases every half-word of the page selected by the address register (index 4, page = address >> PAGE_SHIFT) and leaves the rest alone. With MER set it erases the whole array. MER takes precedence when both are set.
- R9: A program write or a page erase aimed at a page whose `wp_mask` bit is 1 sets WPERR (status bit 4) and starts nothing. A mass erase does the same when any `wp_mask` bit is 1.
- R10: While `busy` is 1, program writes, STRT, and all control and address writes are ignored. A program write in the same cycle as an erase launch is also ignored.
- R11: Writing 1 to status bit 2, 4 or 5 clears that flag, and writing 0 leaves it unchanged. If a flag is set and cleared in the same cycle, it ends up set.
- R12: `op_state` gives 1 while busy. Otherwise it gives 2 if PGERR is set, otherwise 3 if WPERR is set, otherwise 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index (0 key, 1 option key, 2 status, 3 control, 4 address) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register selected by reg_idx |
| mem_wr | input | 1 | Half-word write strobe into the flash window |
| mem_addr | input | ADDR_W | Byte address in the flash window (bit 0 ignored) |
| mem_wdata | input | 16 | Half-word write data |
| mem_rdata | output | 16 | Array content at mem_addr |
| wp_mask | input | NPAGES | Per-page write-protection mask |
| busy | output | 1 | Operation in progress |
| op_state | output | 2 | Prioritised result: 0 done, 1 busy, 2 program error, 3 protection error |

## Verification
Two functions can act on a status flag in the same cycle. One is the hardware setting a flag: a program error raised by a flash-window write, or the end flag raised as an operation completes. The other is a software write-1-to-clear on the register bus. The bench provokes both cases. It drives a program write to a non-erased cell in the same cycle as a clear of PGERR. It also times a clear of EOP to land on the cycle in which the busy count expires. In both cases it expects the flag to read back as set. Around these cases, the bench sweeps the whole array against a model after every program, erase and refused request.

// File: rtl/flash_pe_pkg.sv
`timescale 1ns/1ps
package flash_pe_pkg;
  localparam logic [31:0] KEY_A = 32'h4567_0123;
  localparam logic [31:0] KEY_B = 32'hCDEF_89AB;

  localparam logic [2:0] RI_KEY  = 3'd0;
  localparam logic [2:0] RI_OKEY = 3'd1;
  localparam logic [2:0] RI_STAT = 3'd2;
  localparam logic [2:0] RI_CTRL = 3'd3;
  localparam logic [2:0] RI_ADDR = 3'd4;

  localparam int CB_PG    = 0;
  localparam int CB_PER   = 1;
  localparam int CB_MER   = 2;
  localparam int CB_OPTPG = 4;
  localparam int CB_OPTER = 5;
  localparam int CB_STRT  = 6;
  localparam int CB_LOCK  = 7;

  localparam int SB_BSY   = 0;
  localparam int SB_PGERR = 2;
  localparam int SB_WPERR = 4;
  localparam int SB_EOP   = 5;

  typedef enum logic [1:0] {OP_PROG = 2'd0, OP_PAGE = 2'd1, OP_MASS = 2'd2} op_kind_t;
  typedef enum logic [1:0] {KS_IDLE = 2'd0, KS_HALF = 2'd1, KS_OPEN = 2'd2, KS_DEAD = 2'd3} key_state_t;
  typedef enum logic [1:0] {RES_DONE = 2'd0, RES_BUSY = 2'd1, RES_PGERR = 2'd2, RES_WPERR = 2'd3} op_res_t;
endpackage

// File: rtl/flash_key_unlock.sv
`timescale 1ns/1ps
module flash_key_unlock
  import flash_pe_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_wr,
  input  logic [31:0] key_data,
  input  logic        relock,
  output logic        open
);
  key_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (relock) begin
      st_d = (st_q == KS_DEAD) ? KS_DEAD : KS_IDLE;
    end else begin
      case (st_q)
        KS_IDLE: if (key_wr) st_d = (key_data == KEY_A) ? KS_HALF : KS_DEAD;
        KS_HALF: if (key_wr) st_d = (key_data == KEY_B) ? KS_OPEN : KS_DEAD;
        KS_OPEN: st_d = KS_OPEN;
        default: st_d = KS_DEAD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KS_IDLE;
    else        st_q <= st_d;
  end

  assign open = (st_q == KS_OPEN);

  p_open_after_keyb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open) |-> $past(key_wr && key_data == KEY_B));
  p_dead_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == KS_DEAD) |=> (st_q == KS_DEAD));
endmodule

// File: rtl/flash_op_seq.sv
`timescale 1ns/1ps
module flash_op_seq
  import flash_pe_pkg::*;
#(
  parameter int OP_LAT = 4,
  parameter int IDX_W  = 7,
  parameter int PG_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  op_kind_t         st_kind,
  input  logic [IDX_W-1:0] st_idx,
  input  logic [15:0]      st_data,
  input  logic [PG_W-1:0]  st_page,
  input  logic             err_pg,
  input  logic             err_wp,
  input  logic             clr_pg,
  input  logic             clr_wp,
  input  logic             clr_eop,
  output logic             busy,
  output logic             done,
  output op_kind_t         op_kind,
  output logic [IDX_W-1:0] op_idx,
  output logic [15:0]      op_data,
  output logic [PG_W-1:0]  op_page,
  output logic             pgerr,
  output logic             wperr,
  output logic             eop
);
  localparam int CNT_W = $clog2(OP_LAT + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(OP_LAT - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  op_kind_t         kind_q, kind_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [15:0]      data_q, data_d;
  logic [PG_W-1:0]  page_q, page_d;
  logic             pgerr_q, pgerr_d, wperr_q, wperr_d, eop_q, eop_d;

  assign done = busy_q && (cnt_q == '0);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    kind_d = kind_q;
    idx_d  = idx_q;
    data_d = data_q;
    page_d = page_q;
    if (done) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d = cnt_q - 1'b1;
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = CNT_LOAD;
      kind_d = st_kind;
      idx_d  = st_idx;
      data_d = st_data;
      page_d = st_page;
    end
    pgerr_d = err_pg | (pgerr_q & ~clr_pg);
    wperr_d = err_wp | (wperr_q & ~clr_wp);
    eop_d   = done   | (eop_q   & ~clr_eop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      kind_q  <= OP_PROG;
      idx_q   <= '0;
      data_q  <= '0;
      page_q  <= '0;
      pgerr_q <= 1'b0;
      wperr_q <= 1'b0;
      eop_q   <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      cnt_q   <= cnt_d;
      kind_q  <= kind_d;
      idx_q   <= idx_d;
      data_q  <= data_d;
      page_q  <= page_d;
      pgerr_q <= pgerr_d;
      wperr_q <= wperr_d;
      eop_q   <= eop_d;
    end
  end

  assign busy    = busy_q;
  assign op_kind = kind_q;
  assign op_idx  = idx_q;
  assign op_data = data_q;
  assign op_page = page_q;
  assign pgerr   = pgerr_q;
  assign wperr   = wperr_q;
  assign eop     = eop_q;

  p_launch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q) |=> busy_q);
  p_hold_while_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> (busy_q && $stable(idx_q) && $stable(kind_q) && $stable(data_q)));
  p_eop_after_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> eop_q);
  p_pgerr_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pgerr_q && !clr_pg) |=> pgerr_q);
endmodule

// File: rtl/flash_array_stub.sv
`timescale 1ns/1ps
module flash_array_stub
  import flash_pe_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int PAGE_SHIFT = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           commit,
  input  op_kind_t                       kind,
  input  logic [ADDR_W-2:0]              idx,
  input  logic [15:0]                    data,
  input  logic [ADDR_W-PAGE_SHIFT-1:0]   page,
  input  logic [ADDR_W-2:0]              rd_idx,
  output logic [15:0]                    rd_data
);
  localparam int IDX_W = ADDR_W - 1;
  localparam int NHW   = 1 << IDX_W;
  localparam int SUB_W = PAGE_SHIFT - 1;

  logic [NHW-1:0][15:0] mem_q, mem_d;

  always_comb begin
    mem_d = mem_q;
    if (commit) begin
      case (kind)
        OP_PROG: mem_d[idx] = data;
        OP_PAGE: begin
          for (int i = 0; i < NHW; i++) begin
            if ((IDX_W'(i) >> SUB_W) == IDX_W'(page)) mem_d[i] = 16'hFFFF;
          end
        end
        default: mem_d = '1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mem_q <= '1;
    else if (commit) mem_q <= mem_d;
  end

  assign rd_data = mem_q[rd_idx];

  p_mass_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && kind == OP_MASS) |=> (mem_q == '1));
  p_prog_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && kind == OP_PROG) |=> (mem_q[$past(idx)] == $past(data)));
endmodule

// File: rtl/flash_pe_ctrl.sv
`timescale 1ns/1ps
module flash_pe_ctrl
  import flash_pe_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int PAGE_SHIFT = 5,
  parameter int OP_LAT     = 4,
  parameter int NPAGES     = 1 << (ADDR_W - PAGE_SHIFT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_idx,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              mem_wr,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [15:0]       mem_wdata,
  output logic [15:0]       mem_rdata,
  input  logic [NPAGES-1:0] wp_mask,
  output logic              busy,
  output logic [1:0]        op_state
);
  localparam int IDX_W = ADDR_W - 1;
  localparam int PG_W  = ADDR_W - PAGE_SHIFT;

  // reset: asynchronous assert, synchronous release
  logic rst_q1, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_q1     <= 1'b1;
      rst_sync_n <= rst_q1;
    end
  end

  // key units: 0 guards the control register, 1 the option bits
  logic [1:0] key_hit, key_open;
  logic       relock, ctrl_open, opt_open;
  assign key_hit[0] = reg_wr && (reg_idx == RI_KEY);
  assign key_hit[1] = reg_wr && (reg_idx == RI_OKEY);

  for (genvar k = 0; k < 2; k++) begin : g_key
    flash_key_unlock u_key (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .key_wr   (key_hit[k]),
      .key_data (reg_wdata),
      .relock   (relock),
      .open     (key_open[k])
    );
  end
  assign ctrl_open = key_open[0];
  assign opt_open  = key_open[1];

  // control and address registers
  logic              pg_q, per_q, mer_q, optpg_q, opter_q;
  logic              pg_d, per_d, mer_d, optpg_d, opter_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              ctrl_wr_ok, addr_wr_ok, strt;

  assign ctrl_wr_ok = reg_wr && (reg_idx == RI_CTRL) && ctrl_open && !busy;
  assign addr_wr_ok = reg_wr && (reg_idx == RI_ADDR) && !busy;
  assign relock     = ctrl_wr_ok && reg_wdata[CB_LOCK];
  assign strt       = ctrl_wr_ok && !reg_wdata[CB_LOCK] && reg_wdata[CB_STRT]
                      && (reg_wdata[CB_MER] || reg_wdata[CB_PER]);

  always_comb begin
    pg_d    = pg_q;
    per_d   = per_q;
    mer_d   = mer_q;
    optpg_d = optpg_q;
    opter_d = opter_q;
    addr_d  = addr_q;
    if (relock) begin
      pg_d    = 1'b0;
      per_d   = 1'b0;
      mer_d   = 1'b0;
      optpg_d = 1'b0;
      opter_d = 1'b0;
    end else if (ctrl_wr_ok) begin
      pg_d  = reg_wdata[CB_PG];
      per_d = reg_wdata[CB_PER];
      mer_d = reg_wdata[CB_MER];
      if (opt_open) begin
        optpg_d = reg_wdata[CB_OPTPG];
        opter_d = reg_wdata[CB_OPTER];
      end
    end
    if (addr_wr_ok) addr_d = reg_wdata[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pg_q    <= 1'b0;
      per_q   <= 1'b0;
      mer_q   <= 1'b0;
      optpg_q <= 1'b0;
      opter_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      pg_q    <= pg_d;
      per_q   <= per_d;
      mer_q   <= mer_d;
      optpg_q <= optpg_d;
      opter_q <= opter_d;
      addr_q  <= addr_d;
    end
  end

  // request decode and protection / erased checks
  logic [PG_W-1:0]  mem_page, er_page;
  logic [IDX_W-1:0] mem_idx;
  logic             prog_req, wp_prog, wp_erase, cell_erased;
  logic             start, err_pg, err_wp;
  op_kind_t         st_kind;

  assign mem_page    = mem_addr[ADDR_W-1:PAGE_SHIFT];
  assign mem_idx     = mem_addr[ADDR_W-1:1];
  assign er_page     = addr_q[ADDR_W-1:PAGE_SHIFT];
  assign cell_erased = (mem_rdata == 16'hFFFF);
  assign prog_req    = mem_wr && pg_q && !busy && !strt;
  assign wp_prog     = wp_mask[mem_page];
  assign wp_erase    = reg_wdata[CB_MER] ? (|wp_mask) : wp_mask[er_page];

  always_comb begin
    st_kind = OP_PROG;
    if (strt) st_kind = reg_wdata[CB_MER] ? OP_MASS : OP_PAGE;
  end

  assign start  = (strt && !wp_erase) || (prog_req && !wp_prog && cell_erased);
  assign err_wp = (strt && wp_erase) || (prog_req && wp_prog);
  assign err_pg = prog_req && !wp_prog && !cell_erased;

  logic             clr_wr, done, pgerr, wperr, eop;
  op_kind_t         op_kind;
  logic [IDX_W-1:0] op_idx;
  logic [15:0]      op_data;
  logic [PG_W-1:0]  op_page;

  assign clr_wr = reg_wr && (reg_idx == RI_STAT);

  flash_op_seq #(.OP_LAT(OP_LAT), .IDX_W(IDX_W), .PG_W(PG_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start   (start),
    .st_kind (st_kind),
    .st_idx  (mem_idx),
    .st_data (mem_wdata),
    .st_page (er_page),
    .err_pg  (err_pg),
    .err_wp  (err_wp),
    .clr_pg  (clr_wr && reg_wdata[SB_PGERR]),
    .clr_wp  (clr_wr && reg_wdata[SB_WPERR]),
    .clr_eop (clr_wr && reg_wdata[SB_EOP]),
    .busy    (busy),
    .done    (done),
    .op_kind (op_kind),
    .op_idx  (op_idx),
    .op_data (op_data),
    .op_page (op_page),
    .pgerr   (pgerr),
    .wperr   (wperr),
    .eop     (eop)
  );

  flash_array_stub #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_arr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .commit  (done),
    .kind    (op_kind),
    .idx     (op_idx),
    .data    (op_data),
    .page    (op_page),
    .rd_idx  (mem_idx),
    .rd_data (mem_rdata)
  );

  // read mux and prioritised result
  always_comb begin
    reg_rdata = '0;
    case (reg_idx)
      RI_STAT: begin
        reg_rdata[SB_BSY]   = busy;
        reg_rdata[SB_PGERR] = pgerr;
        reg_rdata[SB_WPERR] = wperr;
        reg_rdata[SB_EOP]   = eop;
      end
      RI_CTRL: begin
        reg_rdata[CB_PG]    = pg_q;
        reg_rdata[CB_PER]   = per_q;
        reg_rdata[CB_MER]   = mer_q;
        reg_rdata[CB_OPTPG] = optpg_q;
        reg_rdata[CB_OPTER] = opter_q;
        reg_rdata[CB_LOCK]  = !ctrl_open;
      end
      RI_ADDR: reg_rdata[ADDR_W-1:0] = addr_q;
      default: reg_rdata = '0;
    endcase
  end

  always_comb begin
    if (busy)       op_state = RES_BUSY;
    else if (pgerr) op_state = RES_PGERR;
    else if (wperr) op_state = RES_WPERR;
    else            op_state = RES_DONE;
  end

  p_locked_modes_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ctrl_open |=> $stable({pg_q, per_q, mer_q}));
  p_opt_gate_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !opt_open |-> (!optpg_q && !opter_q));
  p_pgerr_no_launch_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_pg |=> !busy);
  p_wperr_no_launch_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_wp |=> !busy);
endmodule

// File: tb/flash_pe_ctrl_tb_top.sv
`timescale 1ns/1ps
module flash_pe_ctrl_tb_top;
  localparam int ADDR_W = 8;
  localparam int PSH    = 5;
  localparam int LAT    = 4;
  localparam int NP     = 1 << (ADDR_W - PSH);
  localparam int NHW    = 1 << (ADDR_W - 1);
  localparam int HPP    = 1 << (PSH - 1);
  localparam logic [31:0] K1 = 32'h4567_0123;
  localparam logic [31:0] K2 = 32'hCDEF_89AB;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0;
  logic [2:0]        reg_idx = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              mem_wr = 1'b0;
  logic [ADDR_W-1:0] mem_addr = '0;
  logic [15:0]       mem_wdata = '0;
  logic [15:0]       mem_rdata;
  logic [NP-1:0]     wp_mask = '0;
  logic              busy;
  logic [1:0]        op_state;

  int total = 0;
  int bad = 0;
  logic [15:0] mdl [NHW];

  always #2 clk = ~clk;

  flash_pe_ctrl #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PSH), .OP_LAT(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .wp_mask(wp_mask), .busy(busy), .op_state(op_state)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] i, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = i; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wr_mem(input logic [ADDR_W-1:0] a, input logic [15:0] d);
    @(negedge clk);
    mem_wr = 1'b1; mem_addr = a; mem_wdata = d;
    @(negedge clk);
    mem_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] i, output logic [31:0] v);
    reg_idx = i;
    #1 v = reg_rdata;
  endtask

  task automatic rd_mem(input logic [ADDR_W-1:0] a, output logic [15:0] v);
    mem_addr = a;
    #1 v = mem_rdata;
  endtask

  task automatic chk_reg(input string tag, input logic [2:0] i, input logic [31:0] exp);
    logic [31:0] v;
    rd_reg(i, v);
    chk(tag, v, exp);
  endtask

  task automatic sweep(input string tag);
    int mism = 0;
    logic [15:0] v;
    for (int i = 0; i < NHW; i++) begin
      rd_mem(ADDR_W'(i * 2), v);
      if (v !== mdl[i]) mism++;
    end
    chk(tag, mism, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < NHW; i++) mdl[i] = 16'hFFFF;
  endtask

  task automatic unlock(input logic [2:0] i);
    wr_reg(i, K1);
    wr_reg(i, K2);
  endtask

  function automatic logic [15:0] pdat(input int i);
    return 16'(i * 16'h0123 + 16'h0F0F);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog expired actual=running expected=finished");
    total++;
    bad++;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    do_reset();
    // R1 reset state
    chk_reg("R1 ctrl", 3'd3, 32'h80);
    chk_reg("R1 status", 3'd2, 32'h0);
    chk("R1 busy", busy, 0);
    chk("R1 op_state", op_state, 0);
    sweep("R1 array erased");

    // R3 wrong first key
    wr_reg(3'd0, 32'h1234_5678);
    unlock(3'd0);
    wr_reg(3'd3, 32'h1);
    chk_reg("R3 wrong first key", 3'd3, 32'h80);
    // R3 keys out of order
    do_reset();
    wr_reg(3'd0, K1);
    wr_reg(3'd0, K1);
    unlock(3'd0);
    wr_reg(3'd3, 32'h1);
    chk_reg("R3 bad second key", 3'd3, 32'h80);

    // R2 unlock
    do_reset();
    unlock(3'd0);
    chk_reg("R2 unlocked", 3'd3, 32'h00);
    wr_reg(3'd3, 32'h1);
    chk_reg("R2 PG set", 3'd3, 32'h01);

    // R5 option bits gated
    wr_reg(3'd3, 32'h31);
    chk_reg("R5 opt locked", 3'd3, 32'h01);
    unlock(3'd1);
    wr_reg(3'd3, 32'h31);
    chk_reg("R5 opt open", 3'd3, 32'h31);
    wr_reg(3'd3, 32'h01);

    // R6 program pages 0 and 1
    for (int i = 0; i < 2 * HPP; i++) begin
      wr_mem(ADDR_W'(i * 2), pdat(i));
      if (i == 0) begin
        chk("R6 busy raised", busy, 1);
        chk("R12 busy state", op_state, 1);
        repeat (LAT - 1) @(negedge clk);
        chk("R6 busy last cycle", busy, 1);
        @(negedge clk);
        chk("R6 busy cleared", busy, 0);
      end else begin
        repeat (LAT) @(negedge clk);
      end
      mdl[i] = pdat(i);
    end
    chk_reg("R6 eop", 3'd2, 32'h20);
    sweep("R6 programmed");
    wr_mem(8'h40, 16'hBEEF); repeat (LAT) @(negedge clk);
    wr_mem(8'h42, 16'hDEAD); repeat (LAT) @(negedge clk);
    mdl[8'h20] = 16'hBEEF; mdl[8'h21] = 16'hDEAD;
    rd_mem(8'h40, v); chk("R6 word low half", v, 16'hBEEF);
    rd_mem(8'h42, v); chk("R6 word high half", v, 16'hDEAD);

    // R7 program non-erased
    wr_mem(8'h00, 16'h0000);
    chk("R7 no busy", busy, 0);
    chk_reg("R7 pgerr", 3'd2, 32'h24);
    chk("R12 pgerr state", op_state, 2);
    rd_mem(8'h00, v); chk("R7 unchanged", v, pdat(0));

    // R9 protected program, R12 priority
    wp_mask = 8'h08;
    wr_mem(8'h60, 16'h1234);
    chk("R9 no busy", busy, 0);
    chk_reg("R9 wperr", 3'd2, 32'h34);
    chk("R12 pgerr over wperr", op_state, 2);
    sweep("R9 array untouched");

    // R11 write-1-to-clear
    wr_reg(3'd2, 32'h0);
    chk_reg("R11 zero write", 3'd2, 32'h34);
    wr_reg(3'd2, 32'h04);
    chk_reg("R11 clear pgerr", 3'd2, 32'h30);
    chk("R12 wperr state", op_state, 3);
    wr_reg(3'd2, 32'h30);
    chk_reg("R11 clear rest", 3'd2, 32'h0);
    chk("R12 done state", op_state, 0);

    // R10 requests during busy
    wr_mem(8'h80, 16'h1111);
    wr_mem(8'h82, 16'h2222);
    wr_reg(3'd3, 32'h44);
    repeat (LAT - 2) @(negedge clk);
    mdl[8'h40] = 16'h1111;
    chk_reg("R10 ctrl kept", 3'd3, 32'h01);
    sweep("R10 ignored writes");
    chk_reg("R10 status", 3'd2, 32'h20);

    // R8 page erase
    wr_reg(3'd3, 32'h02);
    wr_reg(3'd4, 32'h25);
    wr_reg(3'd3, 32'h42);
    chk("R8 erase busy", busy, 1);
    repeat (LAT) @(negedge clk);
    for (int i = HPP; i < 2 * HPP; i++) mdl[i] = 16'hFFFF;
    sweep("R8 page erase");
    // R9 protected page erase
    wr_reg(3'd4, 32'h60);
    wr_reg(3'd3, 32'h42);
    chk("R9 erase refused", busy, 0);
    chk_reg("R9 erase wperr", 3'd2, 32'h30);
    sweep("R9 erase untouched");
    wr_reg(3'd2, 32'h30);
    // R8 mass erase with both modes
    wp_mask = '0;
    wr_reg(3'd3, 32'h46);
    repeat (LAT) @(negedge clk);
    for (int i = 0; i < NHW; i++) mdl[i] = 16'hFFFF;
    sweep("R8 mass erase");
    chk_reg("R8 ctrl modes", 3'd3, 32'h06);

    // R11 set and clear in the same cycle
    wr_reg(3'd3, 32'h01);
    wr_mem(8'h10, 16'h0101); repeat (LAT) @(negedge clk);
    wr_reg(3'd2, 32'h20);
    chk_reg("R11 eop cleared", 3'd2, 32'h0);
    @(negedge clk);
    mem_wr = 1'b1; mem_addr = 8'h10; mem_wdata = 16'h0;
    reg_wr = 1'b1; reg_idx = 3'd2; reg_wdata = 32'h04;
    @(negedge clk);
    mem_wr = 1'b0; reg_wr = 1'b0;
    chk_reg("R11 pgerr set wins", 3'd2, 32'h04);
    wr_reg(3'd2, 32'h04);
    wr_mem(8'h12, 16'h0202);
    repeat (LAT - 2) @(negedge clk);
    wr_reg(3'd2, 32'h20);
    chk_reg("R11 eop set wins", 3'd2, 32'h20);
    mdl[8] = 16'h0101; mdl[9] = 16'h0202;

    // R4 relock
    wr_reg(3'd3, 32'h81);
    chk_reg("R4 relocked", 3'd3, 32'h80);
    wr_reg(3'd3, 32'h01);
    chk_reg("R4 zero no unlock", 3'd3, 32'h80);
    wr_mem(8'h14, 16'h5555);
    chk("R4 no program", busy, 0);
    sweep("R4 array after relock");
    unlock(3'd0);
    chk_reg("R4 reunlock clears modes", 3'd3, 32'h00);
    wr_reg(3'd3, 32'h30);
    chk_reg("R5 opt needs new keys", 3'd3, 32'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule